// File: doc/BRIEF.md
# USB Endpoint Buffer Handshake Controller

This block keeps the handshake state between device firmware and the serial interface engine for every endpoint buffer of a USB device controller. The serial engine reports received packets, completed transmissions and set-up packet arrival. Firmware issues four commands addressed to an endpoint: read status, clear buffer, validate buffer and acknowledge set-up. From these the block keeps a buffer-full flag per buffer, a per-endpoint interrupt bit, a ready-to-receive enable for OUT endpoints and a ready-to-transmit enable for IN endpoints.

Endpoints are numbered so that even indices receive (OUT) and odd indices transmit (IN). Index 0 is the control OUT endpoint and index 1 is the control IN endpoint. Any non-control endpoint can be built double-buffered through a mask parameter. A double-buffered endpoint fills its two buffers in turn and serves them oldest first. A set-up packet on endpoint 0 locks both control endpoints. While an endpoint is locked, its clear and validate commands are refused, and each control endpoint must be acknowledged by firmware on its own before it is released.

Top module: `usb_ep_handshake`

## Requirements
- R1: In a cycle where rst is high, all state is cleared: interrupt bits, buffer-full flags, lockouts, rejected flags and pointers. After reset, irq_bits, buf_full, tx_ready, rx_nak and stat_valid are 0, and rx_ready is 1 on every OUT endpoint.
- R2: A packet received on an OUT endpoint with a free buffer sets that endpoint's interrupt bit and buffer-full flag. A double-buffered endpoint fills its two buffers in turn, and rx_ready stays high until every buffer is full.
- R3: A packet received on an OUT endpoint with no free buffer pulses rx_nak for that endpoint in the next cycle. The flags and the interrupt bit are left as they were.
- R4: A read-status command (cmd_op 0) to an existing endpoint gives stat_valid one cycle later. stat_data then holds the state from before the command: bit 0 buffer 0 full, bit 1 buffer 1 full, bit 2 locked, bit 3 rejected, bit 4 interrupt, bits 7:5 zero. The read clears the interrupt and rejected bits, but an event or a rejection in the same cycle sets them again.
- R5: A clear command (cmd_op 1) to an unlocked OUT endpoint empties its oldest full buffer. It has no effect when no buffer is full.
- R6: A validate command (cmd_op 2) to an unlocked IN endpoint fills its next free buffer. tx_ready is high while the IN endpoint holds a full buffer and is not locked. A transmit-done event empties the oldest full buffer and sets the interrupt bit.
- R7: A set-up packet (sie_rx_setup with endpoint 0) leaves endpoint 0 holding buffer 0 full with its interrupt set. It also flushes every buffer of endpoint 1 and locks both control endpoints, so tx_ready[1] is 0.
- R8: A clear or validate command to a locked endpoint changes no buffer and sets that endpoint's rejected bit, which stays set until a status read.
- R9: An acknowledge command (cmd_op 3) releases the lock only of the control endpoint it names. It is ignored on other endpoints and in a cycle where a set-up packet arrives.
- R10: A clear to an IN endpoint, a validate to an OUT endpoint, any command to an endpoint index at or above NUM_EP, and a received packet addressed to an IN endpoint all leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sie_rx_valid | input | 1 | Serial engine received a packet |
| sie_rx_setup | input | 1 | Received packet is a set-up packet |
| sie_rx_ep | input | EPW | Endpoint of the received packet |
| sie_tx_done | input | 1 | Serial engine finished sending a packet |
| sie_tx_ep | input | EPW | Endpoint of the sent packet |
| cmd_valid | input | 1 | Firmware command strobe |
| cmd_op | input | 2 | 0 read status, 1 clear, 2 validate, 3 acknowledge set-up |
| cmd_ep | input | EPW | Endpoint the command addresses |
| irq_bits | output | NUM_EP | Per-endpoint interrupt bits |
| buf_full | output | NUM_EP | Endpoint holds at least one full buffer |
| rx_ready | output | NUM_EP | OUT endpoint can accept a packet |
| tx_ready | output | NUM_EP | IN endpoint has a validated buffer to send |
| rx_nak | output | NUM_EP | Pulse: packet refused, no free buffer |
| stat_valid | output | 1 | Status read result valid |
| stat_data | output | 8 | Status read result |

## Verification
The bench builds the block with six endpoints and marks endpoints 2, 3 and 4 double-buffered while endpoint 5 stays single. Ping-pong order, the single-buffer full case and both control endpoints are therefore all exercised in one run. With three index bits and six endpoints, the indices 6 and 7 exist on the bus but name no endpoint, so the out-of-range command and event paths can be driven.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;

  typedef enum logic [1:0] {
    HS_READ     = 2'd0,
    HS_CLEAR    = 2'd1,
    HS_VALIDATE = 2'd2,
    HS_ACK      = 2'd3
  } hs_op_e;

  localparam int STAT_W = 8;

  typedef struct packed {
    logic [2:0] pad;
    logic       irq;
    logic       rej;
    logic       lock;
    logic [1:0] full;
  } hs_stat_t;

endpackage

// File: rtl/hs_decode.sv
module hs_decode
  import usb_hs_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic              sie_rx_valid,
  input  logic              sie_rx_setup,
  input  logic [EPW-1:0]    sie_rx_ep,
  input  logic              sie_tx_done,
  input  logic [EPW-1:0]    sie_tx_ep,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [EPW-1:0]    cmd_ep,
  output logic              setup_ev,
  output logic [NUM_EP-1:0] sie_hit,
  output logic [NUM_EP-1:0] cmd_rd,
  output logic [NUM_EP-1:0] cmd_clr,
  output logic [NUM_EP-1:0] cmd_val,
  output logic [NUM_EP-1:0] cmd_ack
);

  assign setup_ev = sie_rx_valid && sie_rx_setup && (sie_rx_ep == '0);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic sel;
    assign sel = cmd_valid && (cmd_ep == EPW'(i));
    if (i % 2 == 1) begin : g_in
      assign sie_hit[i] = sie_tx_done && (sie_tx_ep == EPW'(i));
    end else if (i == 0) begin : g_ctrl_out
      assign sie_hit[i] = sie_rx_valid && !sie_rx_setup && (sie_rx_ep == EPW'(i));
    end else begin : g_out
      assign sie_hit[i] = sie_rx_valid && (sie_rx_ep == EPW'(i));
    end
    assign cmd_rd[i]  = sel && (cmd_op == HS_READ);
    assign cmd_clr[i] = sel && (cmd_op == HS_CLEAR);
    assign cmd_val[i] = sel && (cmd_op == HS_VALIDATE);
    assign cmd_ack[i] = sel && (cmd_op == HS_ACK);
  end

endmodule

// File: rtl/hs_ep_slot.sv
module hs_ep_slot
  import usb_hs_pkg::*;
#(
  parameter bit IS_IN   = 1'b0,
  parameter bit IS_CTRL = 1'b0,
  parameter bit DOUBLE  = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     sie_hit,
  input  logic     setup_hit,
  input  logic     flush,
  input  logic     cmd_rd,
  input  logic     cmd_clr,
  input  logic     cmd_val,
  input  logic     cmd_ack,
  output hs_stat_t stat,
  output logic     any_full,
  output logic     rx_rdy,
  output logic     tx_rdy,
  output logic     nak
);

  logic [1:0] full_q, n_full;
  logic       wp_q, n_wp;
  logic       rp_q, n_rp;
  logic       irq_q, n_irq;
  logic       lock_q, n_lock;
  logic       rej_q, n_rej;
  logic       nak_q, n_nak;

  // Order inside one cycle: status read, then serial-engine event,
  // then firmware buffer command, then acknowledge.
  always_comb begin
    n_full = full_q;
    n_wp   = wp_q;
    n_rp   = rp_q;
    n_irq  = irq_q;
    n_lock = lock_q;
    n_rej  = rej_q;
    n_nak  = 1'b0;

    if (cmd_rd) begin
      n_irq = 1'b0;
      n_rej = 1'b0;
    end

    if (setup_hit) begin
      n_full = 2'b01;
      n_wp   = DOUBLE;
      n_rp   = 1'b0;
      n_irq  = 1'b1;
      n_lock = 1'b1;
    end else if (flush) begin
      n_full = 2'b00;
      n_wp   = 1'b0;
      n_rp   = 1'b0;
      n_lock = 1'b1;
    end else if (sie_hit) begin
      if (!IS_IN) begin
        if (!n_full[n_wp]) begin
          n_full[n_wp] = 1'b1;
          n_wp         = DOUBLE ? ~n_wp : 1'b0;
          n_irq        = 1'b1;
        end else begin
          n_nak = 1'b1;
        end
      end else if (!n_lock && n_full[n_rp]) begin
        n_full[n_rp] = 1'b0;
        n_rp         = DOUBLE ? ~n_rp : 1'b0;
        n_irq        = 1'b1;
      end
    end

    if (cmd_clr || cmd_val) begin
      if (n_lock) begin
        n_rej = 1'b1;
      end else if (cmd_clr && !IS_IN && n_full[n_rp]) begin
        n_full[n_rp] = 1'b0;
        n_rp         = DOUBLE ? ~n_rp : 1'b0;
      end else if (cmd_val && IS_IN && !n_full[n_wp]) begin
        n_full[n_wp] = 1'b1;
        n_wp         = DOUBLE ? ~n_wp : 1'b0;
      end
    end

    if (cmd_ack && IS_CTRL && !setup_hit && !flush) begin
      n_lock = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 2'b00;
      wp_q   <= 1'b0;
      rp_q   <= 1'b0;
      irq_q  <= 1'b0;
      lock_q <= 1'b0;
      rej_q  <= 1'b0;
      nak_q  <= 1'b0;
    end else begin
      full_q <= n_full;
      wp_q   <= n_wp;
      rp_q   <= n_rp;
      irq_q  <= n_irq;
      lock_q <= n_lock;
      rej_q  <= n_rej;
      nak_q  <= n_nak;
    end
  end

  assign stat     = hs_stat_t'({3'b000, irq_q, rej_q, lock_q, full_q});
  assign any_full = |full_q;
  assign rx_rdy   = !IS_IN && !full_q[wp_q];
  assign tx_rdy   = IS_IN && (|full_q) && !lock_q;
  assign nak      = nak_q;

endmodule

// File: rtl/hs_status_port.sv
module hs_status_port
  import usb_hs_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [EPW-1:0]           cmd_ep,
  input  logic [NUM_EP*STAT_W-1:0] stat_flat,
  output logic                     stat_valid,
  output logic [STAT_W-1:0]        stat_data
);

  logic [STAT_W-1:0] sel_stat;
  logic              hit;

  always_comb begin
    sel_stat = '0;
    hit      = 1'b0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (cmd_ep == EPW'(i)) begin
        sel_stat = stat_flat[i*STAT_W +: STAT_W];
        hit      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_valid <= 1'b0;
      stat_data  <= '0;
    end else begin
      stat_valid <= cmd_valid && (cmd_op == HS_READ) && hit;
      if (cmd_valid && (cmd_op == HS_READ) && hit) begin
        stat_data <= sel_stat;
      end
    end
  end

endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
  import usb_hs_pkg::*;
#(
  parameter int              NUM_EP   = 4,
  parameter logic [NUM_EP-1:0] DBL_MASK = 4'b1100,
  localparam int             EPW      = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sie_rx_valid,
  input  logic              sie_rx_setup,
  input  logic [EPW-1:0]    sie_rx_ep,
  input  logic              sie_tx_done,
  input  logic [EPW-1:0]    sie_tx_ep,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [EPW-1:0]    cmd_ep,
  output logic [NUM_EP-1:0] irq_bits,
  output logic [NUM_EP-1:0] buf_full,
  output logic [NUM_EP-1:0] rx_ready,
  output logic [NUM_EP-1:0] tx_ready,
  output logic [NUM_EP-1:0] rx_nak,
  output logic              stat_valid,
  output logic [STAT_W-1:0] stat_data
);

  logic                     setup_ev;
  logic [NUM_EP-1:0]        sie_hit, cmd_rd, cmd_clr, cmd_val, cmd_ack;
  logic [NUM_EP*STAT_W-1:0] stat_flat;

  hs_decode #(.NUM_EP(NUM_EP)) u_decode (
    .sie_rx_valid (sie_rx_valid),
    .sie_rx_setup (sie_rx_setup),
    .sie_rx_ep    (sie_rx_ep),
    .sie_tx_done  (sie_tx_done),
    .sie_tx_ep    (sie_tx_ep),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_ep       (cmd_ep),
    .setup_ev     (setup_ev),
    .sie_hit      (sie_hit),
    .cmd_rd       (cmd_rd),
    .cmd_clr      (cmd_clr),
    .cmd_val      (cmd_val),
    .cmd_ack      (cmd_ack)
  );

  for (genvar i = 0; i < NUM_EP; i++) begin : g_slot
    hs_stat_t st;
    hs_ep_slot #(
      .IS_IN   (i % 2 == 1),
      .IS_CTRL (i < 2),
      .DOUBLE  ((i >= 2) && DBL_MASK[i])
    ) u_slot (
      .clk       (clk),
      .rst       (rst),
      .sie_hit   (sie_hit[i]),
      .setup_hit ((i == 0) && setup_ev),
      .flush     ((i == 1) && setup_ev),
      .cmd_rd    (cmd_rd[i]),
      .cmd_clr   (cmd_clr[i]),
      .cmd_val   (cmd_val[i]),
      .cmd_ack   (cmd_ack[i]),
      .stat      (st),
      .any_full  (buf_full[i]),
      .rx_rdy    (rx_ready[i]),
      .tx_rdy    (tx_ready[i]),
      .nak       (rx_nak[i])
    );
    assign irq_bits[i]                    = st.irq;
    assign stat_flat[i*STAT_W +: STAT_W]  = st;
  end

  hs_status_port #(.NUM_EP(NUM_EP)) u_status (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_ep     (cmd_ep),
    .stat_flat  (stat_flat),
    .stat_valid (stat_valid),
    .stat_data  (stat_data)
  );

endmodule

// File: rtl/hs_checker.sv
module hs_checker
  import usb_hs_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EPW = $clog2(NUM_EP)
) (
  input logic              clk,
  input logic              rst,
  input logic              sie_rx_valid,
  input logic              sie_rx_setup,
  input logic [EPW-1:0]    sie_rx_ep,
  input logic              sie_tx_done,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [EPW-1:0]    cmd_ep,
  input logic [NUM_EP-1:0] irq_bits,
  input logic [NUM_EP-1:0] buf_full,
  input logic [NUM_EP-1:0] tx_ready,
  input logic [NUM_EP-1:0] rx_nak,
  input logic              stat_valid
);

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (irq_bits == '0) && (buf_full == '0) && !stat_valid); // R1

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ((irq_bits & ~$past(irq_bits)) != '0))
      |-> $past(sie_rx_valid || sie_tx_done)); // R2

  AST_NAK_NEEDS_RX: assert property (@(posedge clk) disable iff (rst)
    (rx_nak != '0) |-> $past(sie_rx_valid)); // R3

  AST_STAT_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> $past(cmd_valid && (cmd_op == HS_READ) && (int'(cmd_ep) < NUM_EP))); // R4

  AST_SETUP_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sie_rx_valid && sie_rx_setup && (sie_rx_ep == '0)))
      |-> buf_full[0] && irq_bits[0] && !tx_ready[1]); // R7

endmodule

bind usb_ep_handshake hs_checker #(.NUM_EP(NUM_EP)) u_hs_checker (
  .clk          (clk),
  .rst          (rst),
  .sie_rx_valid (sie_rx_valid),
  .sie_rx_setup (sie_rx_setup),
  .sie_rx_ep    (sie_rx_ep),
  .sie_tx_done  (sie_tx_done),
  .cmd_valid    (cmd_valid),
  .cmd_op       (cmd_op),
  .cmd_ep       (cmd_ep),
  .irq_bits     (irq_bits),
  .buf_full     (buf_full),
  .tx_ready     (tx_ready),
  .rx_nak       (rx_nak),
  .stat_valid   (stat_valid)
);

// File: tb/usb_ep_handshake_bench.sv
module usb_ep_handshake_bench;

  localparam int N   = 6;
  localparam int EPW = 3;
  localparam logic [N-1:0] DBL = 6'b011100;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           sie_rx_valid = 1'b0, sie_rx_setup = 1'b0, sie_tx_done = 1'b0;
  logic [EPW-1:0] sie_rx_ep = '0, sie_tx_ep = '0, cmd_ep = '0;
  logic           cmd_valid = 1'b0;
  logic [1:0]     cmd_op = '0;
  logic [N-1:0]   irq_bits, buf_full, rx_ready, tx_ready, rx_nak;
  logic           stat_valid;
  logic [7:0]     stat_data;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // model state
  bit mf0 [N], mf1 [N], mwp [N], mrp [N], mirq [N], mlock [N], mrej [N];
  bit [N-1:0] exp_nak;
  bit         exp_sv;
  bit [7:0]   exp_sd;

  always #10 clk = ~clk;

  usb_ep_handshake #(.NUM_EP(N), .DBL_MASK(DBL)) u_usb_ep_handshake (
    .clk(clk), .rst(rst),
    .sie_rx_valid(sie_rx_valid), .sie_rx_setup(sie_rx_setup), .sie_rx_ep(sie_rx_ep),
    .sie_tx_done(sie_tx_done), .sie_tx_ep(sie_tx_ep),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ep(cmd_ep),
    .irq_bits(irq_bits), .buf_full(buf_full), .rx_ready(rx_ready),
    .tx_ready(tx_ready), .rx_nak(rx_nak),
    .stat_valid(stat_valid), .stat_data(stat_data)
  );

  task automatic chk(string lbl, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", lbl, act, exp, $time);
    end
  endtask

  function automatic bit getf(int e, bit idx);
    return idx ? mf1[e] : mf0[e];
  endfunction

  task automatic setf(int e, bit idx, bit v);
    if (idx) mf1[e] = v; else mf0[e] = v;
  endtask

  task automatic model_reset();
    for (int e = 0; e < N; e++) begin
      mf0[e] = 0; mf1[e] = 0; mwp[e] = 0; mrp[e] = 0;
      mirq[e] = 0; mlock[e] = 0; mrej[e] = 0;
    end
    exp_nak = '0; exp_sv = 0; exp_sd = '0;
  endtask

  task automatic model_step(bit rxv, bit rxs, int rxe, bit txd, int txe,
                            bit cv, int cop, int cep);
    bit setup;
    setup   = rxv && rxs && rxe == 0;
    exp_nak = '0;
    exp_sv  = cv && cop == 0 && cep < N;
    if (exp_sv)
      exp_sd = {3'b000, mirq[cep], mrej[cep], mlock[cep], mf1[cep], mf0[cep]};
    for (int e = 0; e < N; e++) begin
      bit isin, dbl, sel, hit;
      isin = (e % 2 == 1);
      dbl  = (e >= 2) && DBL[e];
      sel  = cv && cep == e;
      hit  = isin ? (txd && txe == e) : (rxv && rxe == e && !(e == 0 && rxs));
      if (sel && cop == 0) begin mirq[e] = 0; mrej[e] = 0; end
      if (e == 0 && setup) begin
        mf0[e] = 1; mf1[e] = 0; mwp[e] = 0; mrp[e] = 0; mirq[e] = 1; mlock[e] = 1;
      end else if (e == 1 && setup) begin
        mf0[e] = 0; mf1[e] = 0; mwp[e] = 0; mrp[e] = 0; mlock[e] = 1;
      end else if (hit) begin
        if (!isin) begin
          if (!getf(e, mwp[e])) begin
            setf(e, mwp[e], 1); if (dbl) mwp[e] = ~mwp[e]; mirq[e] = 1;
          end else exp_nak[e] = 1;
        end else if (!mlock[e] && getf(e, mrp[e])) begin
          setf(e, mrp[e], 0); if (dbl) mrp[e] = ~mrp[e]; mirq[e] = 1;
        end
      end
      if (sel && (cop == 1 || cop == 2)) begin
        if (mlock[e]) mrej[e] = 1;
        else if (cop == 1 && !isin && getf(e, mrp[e])) begin
          setf(e, mrp[e], 0); if (dbl) mrp[e] = ~mrp[e];
        end else if (cop == 2 && isin && !getf(e, mwp[e])) begin
          setf(e, mwp[e], 1); if (dbl) mwp[e] = ~mwp[e];
        end
      end
      if (sel && cop == 3 && e < 2 && !setup) mlock[e] = 0;
    end
  endtask

  task automatic compare(string lbl);
    bit [N-1:0] ei, ef, er, et;
    for (int e = 0; e < N; e++) begin
      ei[e] = mirq[e];
      ef[e] = mf0[e] | mf1[e];
      er[e] = (e % 2 == 0) && !getf(e, mwp[e]);
      et[e] = (e % 2 == 1) && (mf0[e] | mf1[e]) && !mlock[e];
    end
    chk({lbl, " irq"},      8'(irq_bits),   8'(ei));
    chk({lbl, " full"},     8'(buf_full),   8'(ef));
    chk({lbl, " rx_ready"}, 8'(rx_ready),   8'(er));
    chk({lbl, " tx_ready"}, 8'(tx_ready),   8'(et));
    chk({lbl, " nak"},      8'(rx_nak),     8'(exp_nak));
    chk({lbl, " stat_valid"}, 8'(stat_valid), 8'(exp_sv));
    if (exp_sv) chk({lbl, " stat_data"}, stat_data, exp_sd);
  endtask

  task automatic step(string lbl, bit rxv, bit rxs, int rxe, bit txd, int txe,
                      bit cv, int cop, int cep);
    @(negedge clk);
    sie_rx_valid = rxv; sie_rx_setup = rxs; sie_rx_ep = EPW'(rxe);
    sie_tx_done  = txd; sie_tx_ep = EPW'(txe);
    cmd_valid    = cv;  cmd_op = 2'(cop); cmd_ep = EPW'(cep);
    model_step(rxv, rxs, rxe, txd, txe, cv, cop, cep);
    @(posedge clk);
    #2;
    compare(lbl);
  endtask

  task automatic idle(string lbl);
    step(lbl, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic cmd(string lbl, int op, int ep);
    step(lbl, 0, 0, 0, 0, 0, 1, op, ep);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    compare("R1 in reset");
    @(negedge clk);
    rst = 1'b0;
    idle("R1 after reset");

    // R2: double-buffered OUT endpoint 2 fills in turn
    step("R2 rx ep2 first", 1, 0, 2, 0, 0, 0, 0, 0);
    step("R2 rx ep2 second", 1, 0, 2, 0, 0, 0, 0, 0);
    // R3: third packet refused
    step("R3 rx ep2 full", 1, 0, 2, 0, 0, 0, 0, 0);
    step("R3 rx ep5 is IN, R10", 1, 0, 5, 0, 0, 0, 0, 0);
    // R4: read status with a concurrent event on another endpoint
    cmd("R4 read ep2", 0, 2);
    step("R4 read ep4 with rx ep4", 1, 0, 4, 0, 0, 1, 0, 4);
    cmd("R4 read ep4 again", 0, 4);
    // R5: clear oldest, then extra clears are no-ops
    cmd("R5 clear ep2", 1, 2);
    step("R5 rx ep2 refill", 1, 0, 2, 0, 0, 0, 0, 0);
    cmd("R5 clear ep2 b", 1, 2);
    cmd("R5 clear ep2 c", 1, 2);
    cmd("R5 clear ep2 empty", 1, 2);
    // R6: validate IN endpoints and send
    cmd("R6 validate ep3", 2, 3);
    cmd("R6 validate ep3 b", 2, 3);
    cmd("R6 validate ep3 full", 2, 3);
    step("R6 tx ep3", 0, 0, 0, 1, 3, 0, 0, 0);
    cmd("R6 validate ep5", 2, 5);
    cmd("R6 validate ep5 full", 2, 5);
    step("R6 tx ep5", 0, 0, 0, 1, 5, 0, 0, 0);
    // R10: misdirected commands
    cmd("R10 validate OUT ep4", 2, 4);
    cmd("R10 clear IN ep3", 1, 3);
    cmd("R10 read ep7", 0, 7);
    cmd("R10 clear ep6", 1, 6);
    // R7: set-up while control IN holds data
    cmd("R7 validate ep1", 2, 1);
    step("R7 setup ep0", 1, 1, 0, 0, 0, 0, 0, 0);
    // R8: locked commands rejected
    cmd("R8 validate ep1 locked", 2, 1);
    cmd("R8 clear ep0 locked", 1, 0);
    cmd("R8 read ep1", 0, 1);
    step("R8 tx ep1 locked", 0, 0, 0, 1, 1, 0, 0, 0);
    // R9: acknowledge each control endpoint separately
    cmd("R9 ack ep3 ignored", 3, 3);
    cmd("R9 ack ep0", 3, 0);
    cmd("R9 validate ep1 still locked", 2, 1);
    step("R9 setup with ack ep1", 1, 1, 0, 0, 0, 1, 3, 1);
    cmd("R9 ack ep1", 3, 1);
    cmd("R9 ack ep0 b", 3, 0);
    cmd("R9 validate ep1", 2, 1);
    cmd("R9 clear ep0", 1, 0);
    cmd("R4 read ep0", 0, 0);

    // mixed random traffic
    for (int k = 0; k < 4000; k++) begin
      bit rxv, rxs, txd, cv;
      int rxe, txe, cop, cep;
      rxv = ($urandom % 100) < 35;
      rxs = ($urandom % 100) < 6;
      rxe = $urandom % 8;
      txd = ($urandom % 100) < 35;
      txe = $urandom % 8;
      cv  = ($urandom % 100) < 60;
      cop = $urandom % 4;
      cep = $urandom % 8;
      step("R2-R10 random mix", rxv, rxs, rxe, txd, txe, cv, cop, cep);
    end

    // reset in the middle of activity
    step("R2 fill before reset", 1, 0, 4, 0, 0, 0, 0, 0);
    @(negedge clk);
    rst = 1'b1;
    sie_rx_valid = 1'b1; sie_rx_ep = 3'd2; cmd_valid = 1'b0;
    model_reset();
    @(posedge clk);
    #2;
    compare("R1 mid-run reset");
    @(negedge clk);
    rst = 1'b0;
    sie_rx_valid = 1'b0;
    idle("R1 after mid-run reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule